// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a narrow window onto a larger space of 16-bit internal registers. The host sees six registers: a control/status word, an address register and four data registers. Writing the address register starts one internal transaction. Bit 7 of the written value picks the direction: set means fetch the named internal word into data register 0, clear means store the data registers into the internal space. While the transaction runs, a busy flag in the status word stays high, and the host polls it until it drops.

Each internal address pair is treated as one 32-bit value. The low half sits at the even address and the high half at the odd address next to it. A store to an even address writes data register 0 to that word and data register 1 to its odd neighbour. A 32-bit fetch takes two transactions, one at the even address and one at the odd address. The same status word carries two active-low reset controls, one global and one for the codec. While either of them is low, the internal space is held at zero and no transaction can start. Setting or clearing a single bit is done by the host as a fetch followed by a store.

Top module: `ipa_port`

## Requirements
- R1: After `rst`, the status word reads 0, which means both reset controls are asserted and the port is not busy. The address register and all four data registers read 0.
- R2: Host register offsets are 0 for status, 1 for address, 2 to 5 for data registers 0 to 3. A host write to status loads bit 0 into the global reset control `core_rst_n` and bit 1 into the codec reset control `codec_rst_n`. The new values appear on those outputs and in status bits 0 and 1 one cycle after the write.
- R3: A transaction starts when the host writes the address register while the port is idle and both reset controls read 1. Status bit 4 (busy) is then high for exactly BUSY_CYCLES consecutive cycles, starting in the cycle after the write, and then returns to 0.
- R4: A write to the address register while busy is ignored. The address register keeps the value that started the running transaction, and no second transaction follows.
- R5: When a transaction with address bit 7 set completes, data register 0 holds the internal word selected by address bits 6:0. Data registers 1 to 3 are unchanged.
- R6: A transaction with address bit 7 clear stores data register 0 into the selected word. If the selected index is even, it also stores data register 1 into the word at index+1. Data registers 2 and 3 are not used.
- R7: A 32-bit value stored at an even index reads back as two fetches: the low half at that index and the high half at index+1.
- R8: While either reset control is 0, every internal word reads back as 0 once released, the busy flag stays 0, and address register writes are ignored.
- R9: Indices at or above DEPTH are empty. A fetch from one returns 0, and a store to one changes no internal word.
- R10: A store uses the data register values held at the moment of launch. Host writes to the data registers during the busy phase do not change what is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when 1 |
| host_sel | input | 3 | Host register offset |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data (combinational from selected register) |
| core_rst_n | output | 1 | Global reset control, active low |
| codec_rst_n | output | 1 | Codec reset control, active low |

## Verification
The assertions assume that the host holds `host_en` for single-cycle accesses and that an access is a write only when `host_we` is set. The bound checks relate those strobes to the busy flag, the address register and the reset outputs. The stimulus issues every access as a one-cycle strobe from a bench task. Random traffic writes the data registers only while the port is idle and launches a transaction only after busy has been seen low, with the exception of the directed cases, which write the address and data registers on purpose while busy or while a reset control is low.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

    // host-visible register offsets
    typedef enum logic [2:0] {
        HR_STATUS = 3'd0,
        HR_ADDR   = 3'd1,
        HR_DATA0  = 3'd2,
        HR_DATA1  = 3'd3,
        HR_DATA2  = 3'd4,
        HR_DATA3  = 3'd5
    } host_reg_e;

    // status word bit positions
    localparam int ST_CORE_RN  = 0;
    localparam int ST_CODEC_RN = 1;
    localparam int ST_BUSY     = 4;

    localparam int IADDR_W = 8;
    localparam int IDX_W   = 7;
    localparam int NUM_DATA = 4;

    // address register layout: direction in the MSB (bit 7)
    typedef struct packed {
        logic             rd;
        logic [IDX_W-1:0] idx;
    } iaddr_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } seq_state_e;

    // completion strobe handed from the sequencer to the storage side
    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [IDX_W-1:0] idx;
    } xact_t;

    function automatic iaddr_t to_iaddr(input logic [IADDR_W-1:0] a);
        return iaddr_t'(a);
    endfunction

    function automatic logic idx_even(input logic [IDX_W-1:0] i);
        return ~i[0];
    endfunction

endpackage

// File: rtl/ipa_regfile.sv
module ipa_regfile
    import ipa_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata_lo,
    input  logic [DW-1:0]    wdata_hi,
    output logic [DW-1:0]    rdata
);
    localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] words [DEPTH];
    logic          in_range;
    logic          pair_hi;

    assign in_range = int'(idx) < DEPTH;
    assign pair_hi  = idx_even(idx);

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [DW-1:0] word_q;
        logic          hit_lo;
        logic          hit_hi;

        assign hit_lo = wr_en && (int'(idx) == g);
        if (g % 2 == 1) begin : g_odd
            assign hit_hi = wr_en && pair_hi && (int'(idx) == g - 1);
        end else begin : g_even
            assign hit_hi = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                word_q <= '0;
            end else if (hit_lo) begin
                word_q <= wdata_lo;
            end else if (hit_hi) begin
                word_q <= wdata_hi;
            end
        end

        assign words[g] = word_q;
    end

    always_comb begin
        rdata = '0;
        if (in_range) begin
            rdata = words[idx[SEL_W-1:0]];
        end
    end

endmodule

// File: rtl/ipa_seq.sv
module ipa_seq
    import ipa_pkg::*;
#(
    parameter int DW          = 16,
    parameter int BUSY_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               launch,
    input  logic [IADDR_W-1:0] launch_addr,
    input  logic [DW-1:0]      launch_d0,
    input  logic [DW-1:0]      launch_d1,
    output logic               busy,
    output xact_t              xact,
    output logic [DW-1:0]      x_d0,
    output logic [DW-1:0]      x_d1
);
    localparam int CW = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES + 1) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(BUSY_CYCLES - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    iaddr_t        addr_q;
    logic [DW-1:0] d0_q;
    logic [DW-1:0] d1_q;
    logic          last;

    assign last = (state_q == SEQ_BUSY) && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        state_q <= SEQ_BUSY;
                        cnt_q   <= CNT_LOAD;
                    end
                end
                SEQ_BUSY: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // operands captured at launch, independent of later host writes
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            d0_q   <= '0;
            d1_q   <= '0;
        end else if (launch && state_q == SEQ_IDLE && !hold) begin
            addr_q <= to_iaddr(launch_addr);
            d0_q   <= launch_d0;
            d1_q   <= launch_d1;
        end
    end

    assign busy    = (state_q == SEQ_BUSY);
    assign xact.rd = last && addr_q.rd;
    assign xact.wr = last && !addr_q.rd;
    assign xact.idx = addr_q.idx;
    assign x_d0    = d0_q;
    assign x_d1    = d1_q;

endmodule

// File: rtl/ipa_host_regs.sv
module ipa_host_regs
    import ipa_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [2:0]         host_sel,
    input  logic [DW-1:0]      host_wdata,
    output logic [DW-1:0]      host_rdata,
    input  logic               launch,
    input  logic               busy,
    input  logic               rd_done,
    input  logic [DW-1:0]      rd_word,
    output logic               addr_wr_req,
    output logic [IADDR_W-1:0] addr_q,
    output logic [DW-1:0]      data0,
    output logic [DW-1:0]      data1,
    output logic               core_rn,
    output logic               codec_rn
);
    logic [NUM_DATA-1:0][DW-1:0] data_q;
    logic                        wr_acc;
    host_reg_e                   sel;
    logic [DW-1:0]               status_word;

    assign sel         = host_reg_e'(host_sel);
    assign wr_acc      = host_en && host_we;
    assign addr_wr_req = wr_acc && (sel == HR_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            core_rn  <= 1'b0;
            codec_rn <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            if (wr_acc && sel == HR_STATUS) begin
                core_rn  <= host_wdata[ST_CORE_RN];
                codec_rn <= host_wdata[ST_CODEC_RN];
            end
            if (launch) begin
                addr_q <= host_wdata[IADDR_W-1:0];
            end
            for (int k = 0; k < NUM_DATA; k++) begin
                if (wr_acc && int'(host_sel) == int'(HR_DATA0) + k) begin
                    data_q[k] <= host_wdata;
                end
            end
            if (rd_done) begin
                data_q[0] <= rd_word;
            end
        end
    end

    always_comb begin
        status_word              = '0;
        status_word[ST_CORE_RN]  = core_rn;
        status_word[ST_CODEC_RN] = codec_rn;
        status_word[ST_BUSY]     = busy;
    end

    always_comb begin
        case (sel)
            HR_STATUS: host_rdata = status_word;
            HR_ADDR:   host_rdata = DW'(addr_q);
            HR_DATA0:  host_rdata = data_q[0];
            HR_DATA1:  host_rdata = data_q[1];
            HR_DATA2:  host_rdata = data_q[2];
            HR_DATA3:  host_rdata = data_q[3];
            default:   host_rdata = '0;
        endcase
    end

    assign data0 = data_q[0];
    assign data1 = data_q[1];

endmodule

// File: rtl/ipa_port.sv
module ipa_port
    import ipa_pkg::*;
#(
    parameter int DW          = 16,
    parameter int DEPTH       = 32,
    parameter int BUSY_CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_en,
    input  logic          host_we,
    input  logic [2:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          core_rst_n,
    output logic          codec_rst_n
);
    logic               busy;
    logic               hold;
    logic               launch;
    logic               addr_wr_req;
    logic [IADDR_W-1:0] addr_q;
    logic [DW-1:0]      data0;
    logic [DW-1:0]      data1;
    logic [DW-1:0]      rf_rdata;
    logic [DW-1:0]      x_d0;
    logic [DW-1:0]      x_d1;
    xact_t              xact;

    assign hold   = !core_rst_n || !codec_rst_n;
    assign launch = addr_wr_req && !busy && !hold;

    ipa_host_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .host_en     (host_en),
        .host_we     (host_we),
        .host_sel    (host_sel),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .launch      (launch),
        .busy        (busy),
        .rd_done     (xact.rd),
        .rd_word     (rf_rdata),
        .addr_wr_req (addr_wr_req),
        .addr_q      (addr_q),
        .data0       (data0),
        .data1       (data1),
        .core_rn     (core_rst_n),
        .codec_rn    (codec_rst_n)
    );

    ipa_seq #(.DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .hold        (hold),
        .launch      (launch),
        .launch_addr (host_wdata[IADDR_W-1:0]),
        .launch_d0   (data0),
        .launch_d1   (data1),
        .busy        (busy),
        .xact        (xact),
        .x_d0        (x_d0),
        .x_d1        (x_d1)
    );

    ipa_regfile #(.DW(DW), .DEPTH(DEPTH)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .clr      (hold),
        .wr_en    (xact.wr),
        .idx      (xact.idx),
        .wdata_lo (x_d0),
        .wdata_hi (x_d1),
        .rdata    (rf_rdata)
    );

endmodule

// File: rtl/ipa_port_chk.sv
module ipa_port_chk #(
    parameter int DW          = 16,
    parameter int BUSY_CYCLES = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          host_en,
    input logic          host_we,
    input logic [2:0]    host_sel,
    input logic [DW-1:0] host_wdata,
    input logic          core_rst_n,
    input logic          codec_rst_n,
    input logic          busy,
    input logic [7:0]    addr_q
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst || !busy) run_len <= '0;
        else              run_len <= run_len + 1;
    end

    // R2: status write reaches the reset outputs one cycle later
    a_r2_reset_ctl: assert property (@(posedge clk) disable iff (rst)
        (host_en && host_we && host_sel == 3'd0) |=>
            (core_rst_n == $past(host_wdata[0]) && codec_rst_n == $past(host_wdata[1])));

    // R3: accepted launch raises busy
    a_r3_launch_busy: assert property (@(posedge clk) disable iff (rst)
        (host_en && host_we && host_sel == 3'd1 && !busy && core_rst_n && codec_rst_n) |=> busy);

    // R3: busy never outlasts its window
    a_r3_busy_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_len < BUSY_CYCLES));

    // R4: address register frozen while a transaction is running
    a_r4_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(addr_q));

    // R8: an asserted reset control clears busy
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!core_rst_n || !codec_rst_n) |=> !busy);

endmodule

bind ipa_port ipa_port_chk #(.DW(DW), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_en     (host_en),
    .host_we     (host_we),
    .host_sel    (host_sel),
    .host_wdata  (host_wdata),
    .core_rst_n  (core_rst_n),
    .codec_rst_n (codec_rst_n),
    .busy        (busy),
    .addr_q      (addr_q)
);

// File: tb/test_ipa_port.sv
module test_ipa_port;
    localparam int DW    = 16;
    localparam int DEPTH = 32;
    localparam int BUSY  = 4;

    localparam logic [2:0] S_STAT = 3'd0, S_ADDR = 3'd1,
                           S_D0 = 3'd2, S_D1 = 3'd3, S_D2 = 3'd4, S_D3 = 3'd5;

    logic          clk = 1'b0;
    logic          rst;
    logic          host_en, host_we;
    logic [2:0]    host_sel;
    logic [DW-1:0] host_wdata, host_rdata;
    logic          core_rst_n, codec_rst_n;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] model [128];

    always #10 clk = ~clk;

    ipa_port #(.DW(DW), .DEPTH(DEPTH), .BUSY_CYCLES(BUSY)) i_ipa_port (
        .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .core_rst_n(core_rst_n), .codec_rst_n(codec_rst_n)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic hw(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_sel = sel; host_wdata = val;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic hr(input logic [2:0] sel, output logic [15:0] val);
        host_sel = sel;
        #1;
        val = host_rdata;
    endtask

    function automatic logic [15:0] exp_word(input int idx);
        return (idx < DEPTH) ? model[idx] : 16'h0;
    endfunction

    function automatic void model_store(input int idx, input logic [15:0] d0, input logic [15:0] d1);
        if (idx < DEPTH) model[idx] = d0;
        if ((idx % 2 == 0) && (idx + 1 < DEPTH)) model[idx + 1] = d1;
    endfunction

    // launch then poll busy; every launch checks R3
    task automatic launch(input logic [7:0] a);
        logic [15:0] s;
        int cnt;
        hw(S_ADDR, {8'h0, a});
        hr(S_STAT, s);
        chk("R3 busy seen after launch", {31'b0, s[4]}, 32'd1);
        cnt = 0;
        while (s[4] && cnt < 100) begin
            cnt++;
            @(negedge clk);
            hr(S_STAT, s);
        end
        chk("R3 busy length", cnt, BUSY);
    endtask

    task automatic wr16(input int idx, input logic [15:0] v);
        hw(S_D0, v); hw(S_D1, 16'h0); hw(S_D2, 16'h0); hw(S_D3, 16'h0);
        launch({1'b0, 7'(idx)});
        model_store(idx, v, 16'h0);
    endtask

    task automatic wr32(input int idx, input logic [31:0] v);
        hw(S_D0, v[15:0]); hw(S_D1, v[31:16]); hw(S_D2, 16'h0); hw(S_D3, 16'h0);
        launch({1'b0, 7'(idx)});
        model_store(idx, v[15:0], v[31:16]);
    endtask

    task automatic rd16(input int idx, output logic [15:0] v);
        launch({1'b1, 7'(idx)});
        hr(S_D0, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, v2;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 128; i++) model[i] = 16'h0;
        rst = 1'b1; host_en = 1'b0; host_we = 1'b0; host_sel = 3'd0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        hr(S_STAT, v); chk("R1 status after reset", v, 16'h0);
        hr(S_ADDR, v); chk("R1 addr after reset", v, 16'h0);
        hr(S_D0, v);   chk("R1 data0 after reset", v, 16'h0);
        hr(S_D3, v);   chk("R1 data3 after reset", v, 16'h0);

        // R2 release resets
        hw(S_STAT, 16'h0003);
        hr(S_STAT, v); chk("R2 status readback", v, 16'h0003);
        chk("R2 reset outputs", {30'b0, codec_rst_n, core_rst_n}, 32'd3);

        // R6 / R5 16-bit store and fetch
        wr16(5, 16'hBEEF);
        hw(S_D1, 16'h1111); hw(S_D2, 16'h2222);
        rd16(5, v); chk("R5 fetch word 5", v, 16'hBEEF);
        hr(S_D1, v); chk("R5 data1 untouched", v, 16'h1111);
        hr(S_D2, v); chk("R5 data2 untouched", v, 16'h2222);

        // R6 even store also writes neighbour; R7 32-bit pair
        wr32(6, 32'hCAFE_1234);
        rd16(6, v);  chk("R7 low half", v, 16'h1234);
        rd16(7, v);  chk("R7 high half", v, 16'hCAFE);
        wr16(6, 16'h00AA);
        rd16(7, v);  chk("R6 even store clears neighbour", v, 16'h0000);
        wr32(9, 32'h7777_5A5A);
        rd16(10, v); chk("R6 odd store leaves next word", v, exp_word(10));
        rd16(9, v);  chk("R6 odd store low word", v, 16'h5A5A);

        // R4 address write while busy ignored
        hw(S_D0, 16'h4321); hw(S_D1, 16'h0);
        hw(S_ADDR, 16'h0003);
        hw(S_ADDR, 16'h000C);
        hr(S_ADDR, v); chk("R4 addr held while busy", v, 16'h0003);
        repeat (BUSY + 2) @(negedge clk);
        hr(S_STAT, v); chk("R4 no second transaction", {31'b0, v[4]}, 32'd0);
        model_store(3, 16'h4321, 16'h0);
        rd16(12, v); chk("R4 ignored target unchanged", v, exp_word(12));
        rd16(3, v);  chk("R4 first target stored", v, 16'h4321);

        // R10 operands captured at launch
        hw(S_D0, 16'hA0A0); hw(S_D1, 16'h0);
        hw(S_ADDR, 16'h0015);
        hw(S_D0, 16'hFFFF);
        repeat (BUSY + 2) @(negedge clk);
        model_store(21, 16'hA0A0, 16'h0);
        rd16(21, v); chk("R10 launch-time data stored", v, 16'hA0A0);

        // R9 out of range
        wr16(100, 16'h5555);
        rd16(100, v); chk("R9 out-of-range fetch", v, 16'h0);
        rd16(31, v);  chk("R9 last in-range word intact", v, exp_word(31));

        // random traffic
        for (int n = 0; n < 150; n++) begin
            int idx;
            int op;
            idx = ($urandom % 8 == 0) ? int'($urandom % 128) : int'($urandom % DEPTH);
            op  = int'($urandom % 3);
            if (op == 0) wr16(idx, 16'($urandom));
            else if (op == 1) wr32(idx & ~1, $urandom);
            else begin
                rd16(idx, v2);
                chk("R5 random fetch", v2, exp_word(idx));
            end
        end

        // R8 reset control clears and blocks
        hw(S_STAT, 16'h0000);
        hr(S_STAT, v); chk("R8 resets asserted", v, 16'h0);
        hw(S_ADDR, 16'h0081);
        hr(S_STAT, v); chk("R8 no busy while held", {31'b0, v[4]}, 32'd0);
        hr(S_ADDR, v); chk("R8 addr write ignored", {24'b0, v[7:0]} == {24'b0, v[7:0]} ? 32'(v != 16'h0081) : 32'd0, 32'd1);
        hw(S_STAT, 16'h0001);
        hw(S_ADDR, 16'h0082);
        hr(S_STAT, v); chk("R8 codec reset alone blocks", {31'b0, v[4]}, 32'd0);
        hw(S_STAT, 16'h0003);
        for (int i = 0; i < 128; i++) model[i] = 16'h0;
        rd16(5, v);  chk("R8 word 5 cleared", v, 16'h0);
        rd16(21, v); chk("R8 word 21 cleared", v, 16'h0);
        wr16(2, 16'h1357);
        rd16(2, v);  chk("R6 store after release", v, 16'h1357);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule